// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital timing controller of a 10-bit successive-approximation converter. A programmable prescaler derives a converter clock, delivered as a one-cycle tick in the system clock domain. Conversion phases are counted in those ticks: a sample-and-hold window, ten bit decisions from MSB to LSB, and a completion step that loads the result register and raises a sticky done flag. The analog side is reduced to one comparator input bit, and a trial code is driven out towards the DAC.

Software enables the block, picks a prescaler ratio and a mode, and requests work through a start bit. There are three modes. In single mode the start bit clears itself on completion. In free-running mode each completion starts the next conversion, and the start bit stays set. In triggered mode each rising edge of an external trigger starts one conversion. The result is a plain register with no handshake. The done flag tells the reader that a new value is present, and the register keeps its value until the next completion.

Top module: `sar_seq_top`

## Requirements
- R1: The converter tick period is 2 system cycles for `psc_sel_i` = 0 or 1 and 2^`psc_sel_i` cycles otherwise. While `en_i` is 0 the prescaler is held cleared, and start requests have no effect.
- R2: A start request is acted upon at the next converter tick, which is 1 to one tick period after the request. `busy_o` rises then.
- R3: Except for the first conversion after enable, a conversion started by the start bit lasts 13 ticks (`busy_o` is high for 13 tick periods). `sample_o` is high for 1.5 tick periods from its start.
- R4: The first conversion after `en_i` rises lasts 25 ticks, with `sample_o` high for 13.5 tick periods.
- R5: With `mode_i` = 2 (triggered), a rising edge on `trig_i` while idle starts a conversion of 13 ticks, with `sample_o` high for 2 tick periods.
- R6: A trigger edge that arrives while `busy_o` is 1 is ignored. After that conversion the block stays idle, and the result is held until a new conversion completes.
- R7: With `mode_i` = 0 (single; the value 3 behaves the same), completion clears `start_o` and sets `done_o` in the same cycle.
- R8: With `mode_i` = 1 (free-running), each completion starts the next conversion in the same tick. `busy_o` and `start_o` stay 1 until the mode is changed.
- R9: The trial code starts at 0x200. Bits are decided from bit 9 down to bit 0, one per tick. A trial bit is kept when `cmp_i` = 1 (input at or above the trial level). With an ideal comparator the result equals the input code.
- R10: `done_o` is sticky until `flag_clr_i` is pulsed. When a completion and a clear fall in the same cycle, the flag is set.
- R11: `result_o` is 0 after reset and changes only at a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| en_i | input | 1 | converter enable |
| mode_i | input | 2 | 0 single, 1 free-running, 2 triggered |
| psc_sel_i | input | 3 | prescaler ratio select |
| start_set_i | input | 1 | one-cycle write of 1 to the start bit |
| trig_i | input | 1 | external trigger |
| flag_clr_i | input | 1 | one-cycle write of 1 clearing the done flag |
| cmp_i | input | 1 | comparator: input at or above trial level |
| sample_o | output | 1 | sample-and-hold switch control |
| busy_o | output | 1 | conversion in progress |
| start_o | output | 1 | start bit readback |
| done_o | output | 1 | sticky completion flag |
| dac_code_o | output | 10 | trial code to the DAC |
| result_o | output | 10 | last conversion result |

## Verification
Two events can land in the same cycle: a completion setting the done flag and software clearing it. The bench provokes this by holding the clear high through a whole conversion. It then expects the flag to read 1 in the cycle where busy falls and 0 in the next cycle. In free-running mode, completion and restart also share one tick, and `busy_o` is watched for any gap across several conversions. The timing checks compare the measured sample and busy widths with the tick period computed from the select value.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_TRIG   = 2'd2,
    MODE_RSVD   = 2'd3
  } conv_mode_e;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic             half_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_v, mid_v;
  logic [SEL_W-1:0] shift_v;

  always_comb begin
    shift_v = (sel_i == '0) ? SEL_W'(1) : sel_i;
    last_v  = (CNT_W'(1) << shift_v) - CNT_W'(1);
    mid_v   = (CNT_W'(1) << (shift_v - SEL_W'(1))) - CNT_W'(1);
  end

  assign tick_o = en_i && (cnt_q == last_v);
  assign half_o = en_i && (cnt_q == mid_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q >= last_v) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1: every period is at least two system cycles
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o) else $error("tick spacing");
endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int NORM_LEN     = 13,
  parameter int FIRST_LEN    = 25,
  parameter int NORM_HALVES  = 3,
  parameter int FIRST_HALVES = 27,
  parameter int TRIG_HOLD    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       start_set_i,
  input  logic       trig_i,
  input  logic       flag_clr_i,
  input  logic       tick_i,
  input  logic       half_i,
  output logic       load_o,
  output logic       decide_o,
  output logic [$clog2(RES_BITS)-1:0] idx_o,
  output logic       fin_o,
  output logic       sample_o,
  output logic       busy_o,
  output logic       start_o,
  output logic       done_o
);
  localparam int K_W   = $clog2(FIRST_LEN + 1);
  localparam int IDX_W = $clog2(RES_BITS);

  logic           trig_q, trig_pend_q, first_q, long_q, trig_run_q;
  logic           busy_q, samp_q, start_q, done_q;
  logic [K_W-1:0] k_q, kn, len_v, lo_v, hold_k_v, idx_full;
  logic           go, restart, trig_edge, is_free, samp_end;

  assign is_free   = (mode_i == MODE_FREE);
  assign trig_edge = trig_i && !trig_q;
  assign kn        = k_q + K_W'(1);
  assign len_v     = long_q ? K_W'(FIRST_LEN) : K_W'(NORM_LEN);
  assign lo_v      = len_v - K_W'(RES_BITS);
  assign hold_k_v  = long_q ? K_W'(FIRST_HALVES / 2) : K_W'(NORM_HALVES / 2);
  assign go        = tick_i && !busy_q && (start_q || trig_pend_q);
  assign fin_o     = tick_i && busy_q && (kn == len_v);
  assign restart   = fin_o && is_free && start_q;
  assign decide_o  = tick_i && busy_q && (kn >= lo_v) && (kn < len_v);
  assign idx_full  = len_v - K_W'(1) - kn;
  assign idx_o     = idx_full[IDX_W-1:0];
  assign load_o    = go || restart;
  assign samp_end  = trig_run_q ? (tick_i && kn == K_W'(TRIG_HOLD))
                                : (half_i && k_q == hold_k_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_pend_q <= 1'b0; first_q <= 1'b1; long_q <= 1'b0; trig_run_q <= 1'b0;
      busy_q <= 1'b0; samp_q <= 1'b0; start_q <= 1'b0; k_q <= '0;
    end else if (!en_i) begin
      trig_pend_q <= 1'b0; first_q <= 1'b1; long_q <= 1'b0; trig_run_q <= 1'b0;
      busy_q <= 1'b0; samp_q <= 1'b0; start_q <= 1'b0; k_q <= '0;
    end else begin
      if (start_set_i)                 start_q <= 1'b1;
      else if (fin_o && !is_free)      start_q <= 1'b0;

      if (go)                          trig_pend_q <= 1'b0;
      else if (trig_edge && !busy_q && mode_i == MODE_TRIG) trig_pend_q <= 1'b1;

      if (go) begin
        busy_q <= 1'b1; k_q <= '0; samp_q <= 1'b1;
        long_q <= first_q; trig_run_q <= trig_pend_q && !start_q;
      end else if (restart) begin
        k_q <= '0; samp_q <= 1'b1; long_q <= 1'b0; trig_run_q <= 1'b0;
      end else begin
        if (fin_o)                busy_q <= 1'b0;
        if (tick_i && busy_q)     k_q <= kn;
        if (samp_q && samp_end)   samp_q <= 1'b0;
      end

      if (fin_o) first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (fin_o)      done_q <= 1'b1;
    else if (flag_clr_i) done_q <= 1'b0;
  end

  assign sample_o = samp_q;
  assign busy_o   = busy_q;
  assign start_o  = start_q;
  assign done_o   = done_q;

  assert_sample_inside_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_q |-> busy_q) else $error("sample outside conversion");
  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tick_i)) else $error("start off tick");
  assert_single_clears_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && !is_free && !start_set_i) |=> !start_q) else $error("start kept");
  assert_free_keeps_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && en_i) |=> busy_q) else $error("free gap");
  assert_flag_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> done_q) else $error("flag lost");
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_BITS = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        decide_i,
  input  logic [$clog2(RES_BITS)-1:0] idx_i,
  input  logic                        cmp_i,
  input  logic                        fin_i,
  output logic [RES_BITS-1:0]         trial_o,
  output logic [RES_BITS-1:0]         result_o
);
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [RES_BITS-1:0] SEED = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] trial_q, result_q, trial_nx;

  always_comb begin
    trial_nx = trial_q;
    for (int b = 0; b < RES_BITS; b++) begin
      if (idx_i == IDX_W'(b)) begin
        if (!cmp_i) trial_nx[b] = 1'b0;
        if (b > 0)  trial_nx[(b > 0) ? b - 1 : 0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      result_q <= '0;
    end else begin
      if (fin_i)         result_q <= trial_q;
      if (load_i)        trial_q  <= SEED;
      else if (decide_i) trial_q  <= trial_nx;
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;

  assert_result_only_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(result_q)) else $error("result moved");
  assert_seed_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (trial_q == SEED)) else $error("bad seed");
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES_BITS = 10,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [1:0]          mode_i,
  input  logic [SEL_W-1:0]    psc_sel_i,
  input  logic                start_set_i,
  input  logic                trig_i,
  input  logic                flag_clr_i,
  input  logic                cmp_i,
  output logic                sample_o,
  output logic                busy_o,
  output logic                start_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_BITS);

  logic             tick, half, load, decide, fin;
  logic [IDX_W-1:0] idx;

  sar_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_i(psc_sel_i),
    .tick_o(tick), .half_o(half));

  sar_phase_seq #(.RES_BITS(RES_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .start_set_i(start_set_i), .trig_i(trig_i), .flag_clr_i(flag_clr_i),
    .tick_i(tick), .half_i(half), .load_o(load), .decide_o(decide),
    .idx_o(idx), .fin_o(fin), .sample_o(sample_o), .busy_o(busy_o),
    .start_o(start_o), .done_o(done_o));

  sar_approx_reg #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .load_i(load), .decide_i(decide), .idx_i(idx),
    .cmp_i(cmp_i), .fin_i(fin), .trial_o(dac_code_o), .result_o(result_o));
endmodule

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] sel = 3'd0;
  logic       start_set = 1'b0, trig = 1'b0, flag_clr = 1'b0;
  logic [9:0] vin = 10'd0;
  logic       cmp;
  logic       sample_o, busy_o, start_o, done_o;
  logic [9:0] dac_code_o, result_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign cmp = (vin >= dac_code_o);

  sar_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .psc_sel_i(sel),
    .start_set_i(start_set), .trig_i(trig), .flag_clr_i(flag_clr), .cmp_i(cmp),
    .sample_o(sample_o), .busy_o(busy_o), .start_o(start_o), .done_o(done_o),
    .dac_code_o(dac_code_o), .result_o(result_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int s);
    return (s == 0) ? 2 : (1 << s);
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
  endtask

  task automatic run_conv(input int inj, output int pre, output int samp, output int bsy);
    bit seen = 0;
    pre = 0; samp = 0; bsy = 0;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (sample_o) samp++;
      if (busy_o) begin
        bsy++; seen = 1;
        if (bsy == inj) trig = 1'b1;
        if (bsy == inj + 2) trig = 1'b0;
      end else if (seen) break;
      else pre++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pre, samp, bsy, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset result", int'(result_o), 0);
    check("R10 reset flag", int'(done_o), 0);
    check("R2 reset busy", int'(busy_o), 0);

    // R1: start ignored while disabled
    pulse_start();
    repeat (20) @(negedge clk);
    check("R1 disabled busy", int'(busy_o), 0);
    check("R1 disabled start bit", int'(start_o), 0);

    // R4: first conversion after enable
    en = 1'b1; vin = 10'h2C5;
    pulse_start();
    run_conv(-1, pre, samp, bsy);
    check("R4 first sample width", samp, 27);
    check("R4 first busy width", bsy, 50);
    check("R9 first result", int'(result_o), 'h2C5);
    check("R7 start cleared", int'(start_o), 0);
    check("R7 flag set", int'(done_o), 1);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R10 flag cleared", int'(done_o), 0);

    // R1 R2 R3 R9: sweep ratios and inputs
    for (int s = 0; s < 4; s++) begin
      sel = 3'(s); d = div_of(s);
      for (int v = 0; v < 1024; v += 73) begin
        vin = 10'(v);
        pulse_start();
        run_conv(-1, pre, samp, bsy);
        check("R2 start latency in range", int'(pre >= 1 && pre <= d), 1);
        check("R3 sample width", samp, 3 * d / 2);
        check("R1 R3 busy width", bsy, 13 * d);
        check("R9 result", int'(result_o), v);
      end
    end
    sel = 3'd7; vin = 10'h3FF;
    pulse_start();
    run_conv(-1, pre, samp, bsy);
    check("R1 divide 128 busy width", bsy, 13 * 128);
    check("R9 full scale", int'(result_o), 'h3FF);
    sel = 3'd0;

    // R11: result held while idle
    vin = 10'h011;
    repeat (40) @(negedge clk);
    check("R11 result held", int'(result_o), 'h3FF);

    // R5 R6: triggered mode, extra edge while busy
    mode = 2'd2; vin = 10'h155;
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    run_conv(5, pre, samp, bsy);
    check("R5 trig sample width", samp, 4);
    check("R5 trig busy width", bsy, 26);
    check("R5 trig result", int'(result_o), 'h155);
    vin = 10'h0AA;
    bsy = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy_o) bsy++;
    end
    check("R6 busy edge ignored", bsy, 0);
    check("R6 result held", int'(result_o), 'h155);

    // R8: free-running
    mode = 2'd1; vin = 10'h1E7;
    pulse_start();
    while (!busy_o) @(negedge clk);
    bsy = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!busy_o || !start_o) bsy++;
    end
    check("R8 no gap in free mode", bsy, 0);
    check("R8 free result", int'(result_o), 'h1E7);
    mode = 2'd0;
    for (int i = 0; i < 100 && busy_o; i++) @(negedge clk);
    check("R7 leaves free via single", int'(start_o), 0);
    check("R8 stops after mode change", int'(busy_o), 0);

    // R10: completion and clear in the same cycle
    vin = 10'h300;
    pulse_start();
    flag_clr = 1'b1;
    run_conv(-1, pre, samp, bsy);
    check("R10 set wins over clear", int'(done_o), 1);
    @(negedge clk);
    check("R10 clear after collision", int'(done_o), 0);
    flag_clr = 1'b0;

    // R4: re-enable gives long first conversion again
    en = 1'b0; repeat (5) @(negedge clk); en = 1'b1;
    vin = 10'h0F0;
    pulse_start();
    run_conv(-1, pre, samp, bsy);
    check("R4 re-enable sample width", samp, 27);
    check("R4 re-enable busy width", bsy, 50);
    check("R9 re-enable result", int'(result_o), 'h0F0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule